// File: doc/BRIEF.md
# Hashed Page-Table Group Searcher

This block holds a small set of page-table entry groups in local storage and, on request, searches one group for the entry that translates a given virtual page. Each group has eight slots. Each slot is two 64-bit words: a tag word and a translation word. The tag word carries the abbreviated virtual page number and the segment size code in its upper bits, and flag bits in its low seven bits. The translation word carries the real page number, the referenced and changed status bits, and the protection code.

A requester presents a group index, a 64-bit search key, a flag that selects the primary or secondary hash, and a flag that marks the access as a store. The controller walks the slots from slot 0 upward, one slot per clock. It stops at the first entry that is valid, carries the requested hash kind, and agrees with the key on every bit from bit 7 upward. On a hit it writes the translation word back with the referenced bit set, and with the changed bit set as well for a store. It then reports the hit, the slot number and the updated translation word together with a one-cycle done strobe. If no slot matches, it reports a miss after all eight slots.

The controller has three states. IDLE waits for a request. SCAN examines one slot per cycle. REPORT raises done for one cycle and returns to IDLE. The transitions are: IDLE to SCAN when a request is present; SCAN to SCAN while the current slot does not match and is not slot 7; SCAN to REPORT on a match or after slot 7; REPORT to IDLE always. A separate load port fills the storage while the block is idle.

Top module: `pt_group_search`

## Requirements
- R1: After reset, busy, done and hit are 0, hit_slot is 0 and hit_dword1 is 0. Every stored word is 0, so no slot is valid and any search misses.
- R2: When busy is 0 and ld_en is 1 at a clock edge, ld_data is written to slot ld_slot of group ld_group. ld_half=0 selects the tag word and ld_half=1 selects the translation word. A load while busy is 1 has no effect.
- R3: A slot matches only when its tag word has bit 0 (valid) equal to 1, bit 1 (secondary hash) equal to req_secondary, and bits 63:7 equal to req_key bits 63:7. Bits 6:0 of the key are ignored, and tag bits 6:2 are not compared.
- R4: Slots are examined in ascending order starting at slot 0. When several slots match, the lowest-numbered one is reported.
- R5: A request is taken at a clock edge where busy is 0 and req_valid is 1; busy is 1 from that edge on. For a hit in slot s, done is 1 during the clock cycle that starts s+1 edges after the accepting edge. For a miss, done is 1 during the cycle that starts 8 edges after it.
- R6: On a hit, hit=1 and hit_slot=s. hit_dword1 is the stored translation word with bit 8 (referenced) set, and with bit 7 (changed) also set when req_store is 1; all other bits are unchanged. The same value is written back into the slot.
- R7: On a miss, hit=0, hit_slot=0, hit_dword1=0, and no stored word changes. done lasts exactly one cycle, and hit, hit_slot and hit_dword1 change only in a cycle where done is 1, holding their values until the next result.
- R8: A request presented while busy is 1 is dropped. It neither starts a second search nor produces a second done.
- R9: A search reads only the eight slots of the requested group; entries in other groups never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one storage word (only while idle) |
| ld_group | input | GRP_W | Group index of the word written |
| ld_slot | input | 3 | Slot index of the word written |
| ld_half | input | 1 | 0 = tag word, 1 = translation word |
| ld_data | input | 64 | Word to store |
| req_valid | input | 1 | Search request |
| req_group | input | GRP_W | Group to search |
| req_key | input | 64 | Search key; bits 63:7 compared |
| req_secondary | input | 1 | 1 = looking for a secondary-hash entry |
| req_store | input | 1 | 1 = store access, also sets changed bit |
| busy | output | 1 | Search in progress, requests and loads ignored |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Last result was a hit |
| hit_slot | output | 3 | Slot of the last hit |
| hit_dword1 | output | 64 | Updated translation word of the last hit |

## Verification
If a request is taken at one edge, its result is due s+1 edges later for a hit in slot s, and 8 edges later for a miss. The bench changes inputs on falling edges and samples outputs on falling edges. It counts falling edges from the accepting edge until done appears and compares that count with the figure predicted from its own model of the storage, so a result that arrives early or late fails even when its value is right. Outputs are read in the done cycle and again a few cycles later to check that they hold, and after a dropped request the bench watches twelve more cycles for a stray done.

// File: rtl/pts_pkg.sv
package pts_pkg;
    localparam int DW      = 64;
    localparam int SLOTS   = 8;
    localparam int SLOT_W  = $clog2(SLOTS);

    // tag word flag positions
    localparam int TAG_VALID = 0;
    localparam int TAG_SEC   = 1;
    localparam int TAG_LARGE = 2;
    localparam int TAG_LOCK  = 3;
    localparam int TAG_BOLT  = 4;
    localparam int TAG_CMP_LO = 7;   // lowest compared bit

    // translation word status positions
    localparam int XL_CHG = 7;
    localparam int XL_REF = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } pts_state_e;
endpackage

// File: rtl/pts_mem.sv
module pts_mem
    import pts_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int GRP_W = $clog2(GROUPS),
    localparam int IDX_W = GRP_W + SLOT_W,
    localparam int ENTRIES = GROUPS * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [GRP_W-1:0]  ld_group,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic              ld_half,
    input  logic [DW-1:0]     ld_data,
    input  logic [GRP_W-1:0]  rd_group,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic              upd_we,
    input  logic [DW-1:0]     upd_data,
    output logic [DW-1:0]     rd_tag,
    output logic [DW-1:0]     rd_xlat
);
    logic [IDX_W-1:0] ld_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    tag_all  [ENTRIES];
    logic [DW-1:0]    xlat_all [ENTRIES];

    assign ld_idx = {ld_group, ld_slot};
    assign rd_idx = {rd_group, rd_slot};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
        logic [DW-1:0] tag_r;
        logic [DW-1:0] xlat_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r  <= '0;
                xlat_r <= '0;
            end else begin
                if (ld_we && !ld_half && ld_idx == MY_IDX)
                    tag_r <= ld_data;
                if (upd_we && rd_idx == MY_IDX)
                    xlat_r <= upd_data;
                else if (ld_we && ld_half && ld_idx == MY_IDX)
                    xlat_r <= ld_data;
            end
        end

        assign tag_all[e]  = tag_r;
        assign xlat_all[e] = xlat_r;
    end

    assign rd_tag  = tag_all[rd_idx];
    assign rd_xlat = xlat_all[rd_idx];

    // loads are gated off while a search may write back
    assert_no_write_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_we && upd_we));
endmodule

// File: rtl/pts_match.sv
module pts_match
    import pts_pkg::*;
(
    input  logic [DW-1:0]          tag,
    input  logic [DW-1:TAG_CMP_LO] key_hi,
    input  logic                   want_sec,
    output logic                   match
);
    logic valid_ok;
    logic kind_ok;
    logic vpn_ok;

    always_comb begin
        valid_ok = tag[TAG_VALID];
        kind_ok  = (tag[TAG_SEC] == want_sec);
        vpn_ok   = (tag[DW-1:TAG_CMP_LO] == key_hi);
        match    = valid_ok && kind_ok && vpn_ok;
    end

    // large, lock and bolted flags take no part in matching
    logic flags_unused;
    assign flags_unused = ^{tag[TAG_BOLT], tag[TAG_LOCK], tag[TAG_LARGE], tag[6:5]};
endmodule

// File: rtl/pts_ctrl.sv
module pts_ctrl
    import pts_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int GRP_W = $clog2(GROUPS),
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1),
    localparam int BUSY_MAX = SLOTS + 1,
    localparam int CYC_W = $clog2(BUSY_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [GRP_W-1:0]       req_group,
    input  logic [DW-1:0]          req_key,
    input  logic                   req_secondary,
    input  logic                   req_store,
    input  logic                   entry_match,
    input  logic [DW-1:0]          entry_xlat,
    output logic [GRP_W-1:0]       rd_group,
    output logic [SLOT_W-1:0]      rd_slot,
    output logic [DW-1:TAG_CMP_LO] key_hi,
    output logic                   want_sec,
    output logic                   upd_we,
    output logic [DW-1:0]          upd_data,
    output logic                   busy,
    output logic                   done,
    output logic                   hit,
    output logic [SLOT_W-1:0]      hit_slot,
    output logic [DW-1:0]          hit_dword1
);
    pts_state_e state_q, state_d;
    logic       store_q;

    logic key_low_unused;
    assign key_low_unused = ^req_key[TAG_CMP_LO-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SCAN;
            ST_SCAN:   if (entry_match || rd_slot == LAST_SLOT) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // write-back word for the slot under examination
    always_comb begin
        upd_data = entry_xlat;
        upd_data[XL_REF] = 1'b1;
        if (store_q) upd_data[XL_CHG] = 1'b1;
        upd_we = (state_q == ST_SCAN) && entry_match;
    end

    // request capture, slot walk and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_group   <= '0;
            rd_slot    <= '0;
            key_hi     <= '0;
            want_sec   <= 1'b0;
            store_q    <= 1'b0;
            hit        <= 1'b0;
            hit_slot   <= '0;
            hit_dword1 <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rd_group <= req_group;
                        rd_slot  <= '0;
                        key_hi   <= req_key[DW-1:TAG_CMP_LO];
                        want_sec <= req_secondary;
                        store_q  <= req_store;
                    end
                end
                ST_SCAN: begin
                    if (entry_match) begin
                        hit        <= 1'b1;
                        hit_slot   <= rd_slot;
                        hit_dword1 <= upd_data;
                    end else if (rd_slot == LAST_SLOT) begin
                        hit        <= 1'b0;
                        hit_slot   <= '0;
                        hit_dword1 <= '0;
                    end else begin
                        rd_slot <= rd_slot + 1'b1;
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // status outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_REPORT);
    end

    // cycles spent busy in the current search
    logic [CYC_W-1:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= '0;
        else                 busy_cyc <= busy_cyc + 1'b1;
    end

    assert_scan_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cyc < CYC_W'(BUSY_MAX)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hit_slot) |-> done);

    assert_hit_referenced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> hit_dword1[XL_REF]);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/pt_group_search.sv
module pt_group_search
    import pts_pkg::*;
#(
    parameter int GROUPS = 4,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [GRP_W-1:0]  ld_group,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic              ld_half,
    input  logic [DW-1:0]     ld_data,
    input  logic              req_valid,
    input  logic [GRP_W-1:0]  req_group,
    input  logic [DW-1:0]     req_key,
    input  logic              req_secondary,
    input  logic              req_store,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [DW-1:0]     hit_dword1
);
    logic [GRP_W-1:0]       rd_group;
    logic [SLOT_W-1:0]      rd_slot;
    logic [DW-1:TAG_CMP_LO] key_hi;
    logic                   want_sec;
    logic                   upd_we;
    logic [DW-1:0]          upd_data;
    logic [DW-1:0]          rd_tag;
    logic [DW-1:0]          rd_xlat;
    logic                   entry_match;
    logic                   ld_we;

    assign ld_we = ld_en && !busy;

    pts_mem #(.GROUPS(GROUPS)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_group (ld_group),
        .ld_slot  (ld_slot),
        .ld_half  (ld_half),
        .ld_data  (ld_data),
        .rd_group (rd_group),
        .rd_slot  (rd_slot),
        .upd_we   (upd_we),
        .upd_data (upd_data),
        .rd_tag   (rd_tag),
        .rd_xlat  (rd_xlat)
    );

    pts_match u_match (
        .tag      (rd_tag),
        .key_hi   (key_hi),
        .want_sec (want_sec),
        .match    (entry_match)
    );

    pts_ctrl #(.GROUPS(GROUPS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_group     (req_group),
        .req_key       (req_key),
        .req_secondary (req_secondary),
        .req_store     (req_store),
        .entry_match   (entry_match),
        .entry_xlat    (rd_xlat),
        .rd_group      (rd_group),
        .rd_slot       (rd_slot),
        .key_hi        (key_hi),
        .want_sec      (want_sec),
        .upd_we        (upd_we),
        .upd_data      (upd_data),
        .busy          (busy),
        .done          (done),
        .hit           (hit),
        .hit_slot      (hit_slot),
        .hit_dword1    (hit_dword1)
    );

    assert_miss_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (hit_dword1 == '0));
endmodule

// File: tb/sim_pt_group_search.sv
module sim_pt_group_search;
    localparam int GROUPS = 4;
    localparam int NENT = GROUPS * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_group = '0;
    logic [2:0]  ld_slot = '0;
    logic        ld_half = 1'b0;
    logic [63:0] ld_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_group = '0;
    logic [63:0] req_key = '0;
    logic        req_secondary = 1'b0;
    logic        req_store = 1'b0;
    logic        busy, done, hit;
    logic [2:0]  hit_slot;
    logic [63:0] hit_dword1;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_tag  [NENT];
    logic [63:0] m_xlat [NENT];

    always #10 clk = ~clk;

    pt_group_search #(.GROUPS(GROUPS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_group(ld_group), .ld_slot(ld_slot),
        .ld_half(ld_half), .ld_data(ld_data),
        .req_valid(req_valid), .req_group(req_group), .req_key(req_key),
        .req_secondary(req_secondary), .req_store(req_store),
        .busy(busy), .done(done), .hit(hit),
        .hit_slot(hit_slot), .hit_dword1(hit_dword1)
    );

    localparam logic [63:0] K1 = 64'h4000_1234_5678_9A80;
    localparam logic [63:0] K2 = 64'h0000_0ABC_0000_0100;
    localparam logic [63:0] K3 = 64'h8000_7777_0000_0F80;
    localparam logic [63:0] K4 = 64'h0123_4567_89AB_CD80;
    localparam logic [63:0] K5 = 64'h0FED_CBA9_8765_4300;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input int g, input int s, input bit half, input logic [63:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_group = 2'(g); ld_slot = 3'(s); ld_half = half; ld_data = d;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
        if (half) m_xlat[g*8+s] = d;
        else      m_tag[g*8+s] = d;
    endtask

    task automatic load_entry(input int g, input int s, input logic [63:0] t, input logic [63:0] x);
        load(g, s, 1'b0, t);
        load(g, s, 1'b1, x);
    endtask

    // search with result and timing predicted from the bench model
    task automatic do_search(input int g, input logic [63:0] key, input bit sec, input bit st, input string req);
        int e_slot = -1;
        int n = 0;
        logic [63:0] e_x = '0;
        for (int s = 0; s < 8; s++) begin
            logic [63:0] t = m_tag[g*8+s];
            if (e_slot < 0 && t[0] && t[1] == sec && t[63:7] == key[63:7]) e_slot = s;
        end
        if (e_slot >= 0) begin
            e_x = m_xlat[g*8+e_slot] | 64'h100 | (st ? 64'h80 : 64'h0);
            m_xlat[g*8+e_slot] = e_x;
        end
        @(negedge clk);
        req_valid = 1'b1; req_group = 2'(g); req_key = key; req_secondary = sec; req_store = st;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {req, " R5 busy after accept"}, 64'(busy), 64'd1);
        while (n < 12) begin
            @(negedge clk);
            n++;
            if (done) break;
        end
        chk(n == ((e_slot >= 0) ? e_slot + 1 : 8), {req, " R5 done latency"}, 64'(n),
            64'((e_slot >= 0) ? e_slot + 1 : 8));
        chk(hit == (e_slot >= 0), {req, " R3 hit flag"}, 64'(hit), 64'(e_slot >= 0));
        chk(hit_slot == 3'((e_slot >= 0) ? e_slot : 0), {req, " R4 hit slot"}, 64'(hit_slot),
            64'((e_slot >= 0) ? e_slot : 0));
        chk(hit_dword1 == e_x, {req, " R6 translation word"}, hit_dword1, e_x);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {req, " R7 done one cycle"}, 64'({done, busy}), 64'd0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && hit == 0, "R1 reset flags", 64'({busy, done, hit}), 64'd0);
        chk(hit_slot == 0 && hit_dword1 == 0, "R1 reset result", hit_dword1, 64'd0);
        do_search(0, 64'h0, 1'b0, 1'b0, "R1 empty table");
    endtask

    task automatic t_basic();
        load_entry(0, 3, K1 | 64'h1, 64'h0000_0000_0ABC_D003);
        do_search(0, K1, 1'b0, 1'b0, "R2 R6 basic hit slot 3");
        do_search(0, K1 | 64'h7C, 1'b0, 1'b1, "R3 key flag bits ignored store");
        do_search(0, K1, 1'b0, 1'b0, "R6 written back R C persist");
    endtask

    task automatic t_valid_sec();
        load_entry(0, 1, K2, 64'h0000_0000_1111_0002);
        do_search(0, K2, 1'b0, 1'b0, "R3 invalid entry misses");
        load_entry(0, 6, K3 | 64'h1F, 64'h0000_0000_2222_0001);
        do_search(0, K3, 1'b0, 1'b0, "R3 secondary entry vs primary search");
        do_search(0, K3, 1'b1, 1'b0, "R3 secondary search hits slot 6");
    endtask

    task automatic t_tag_bits();
        do_search(0, K1 ^ 64'h80, 1'b0, 1'b0, "R3 bit 7 differs");
        do_search(0, K1 ^ 64'h8000_0000_0000_0000, 1'b0, 1'b1, "R3 bit 63 differs");
        do_search(0, K1, 1'b0, 1'b0, "R7 miss left entry unchanged");
    endtask

    task automatic t_priority();
        load_entry(1, 5, K4 | 64'h1, 64'h0000_0000_5555_0000);
        load_entry(1, 2, K4 | 64'h1D, 64'h0000_0000_3333_0003);
        do_search(1, K4, 1'b0, 1'b0, "R4 lowest slot wins");
        load_entry(1, 7, K5 | 64'h1, 64'h0000_0000_7777_0000);
        do_search(1, K5, 1'b0, 1'b1, "R5 last slot hit");
    endtask

    task automatic t_groups();
        do_search(2, K4, 1'b0, 1'b0, "R9 other group misses");
        load_entry(2, 0, K4 | 64'h1, 64'h0000_0000_AAAA_0001);
        do_search(2, K4, 1'b0, 1'b0, "R9 own group slot 0");
    endtask

    task automatic t_busy();
        int n = 0;
        int extra = 0;
        @(negedge clk);
        req_valid = 1'b1; req_group = 2'd3; req_key = K1; req_secondary = 1'b0; req_store = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // during the scan: a hitting request and a load, both to be dropped
        req_group = 2'd0; ld_en = 1'b1; ld_group = 2'd0; ld_slot = 3'd3; ld_half = 1'b1;
        ld_data = 64'hDEAD_BEEF_DEAD_BEEF;
        repeat (3) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0; ld_en = 1'b0;
        while (n < 12 && !done) begin
            @(negedge clk);
            n++;
        end
        chk(n == 8 && hit == 0, "R8 original search completes as miss", 64'(n), 64'd8);
        repeat (12) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8 no second done", 64'(extra), 64'd0);
        do_search(0, K1, 1'b0, 1'b0, "R2 load while busy ignored");
    endtask

    task automatic t_hold();
        logic [63:0] x;
        logic [2:0]  s;
        do_search(1, K4, 1'b0, 1'b1, "R6 store sets changed");
        x = hit_dword1; s = hit_slot;
        repeat (4) @(negedge clk);
        chk(hit == 1 && hit_slot == s && hit_dword1 == x, "R7 result holds", hit_dword1, x);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_tag[i] = '0;
            m_xlat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_valid_sec();
        t_tag_bits();
        t_priority();
        t_groups();
        t_busy();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule